// File: doc/BRIEF.md
# Line-Fill Read Bus Master

This block is the processor-side master for read cycles on a 32-bit external bus whose strobes are active low. A request carries a 16-byte line address, a hint that the core would like the line cached, and a hint that caching must be disabled for the page. The block opens the cycle with a one-clock address strobe. It drives the word address, the burst-last strobe, the cache-request strobe and the page-cache-disable output. It then collects either one word or four words as the ready strobe arrives, with any number of wait states between them.

Two answers come back from the system through the cache-enable input, and each is read at its own point. The first is whether the read becomes a four-beat line fill. That value is taken at the clock edge just before the first ready. The second is whether the filled line may be stored in the cache. That value is taken at the edge just before the last ready. A read becomes a burst only when the cache request was driven. When the core does not ask for caching, an asserted cache-enable still produces a single transfer.

Requests enter over a valid/ready handshake. `req_ready` is high only while the block is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. Results leave over a valid/ready handshake as well. `rsp_valid` stays high, with all response fields frozen, until the consumer raises `rsp_ready`. No new request is accepted until that response has been consumed, so a slow consumer stalls the bus master.

Top module: `linefill_rd_master`

## Requirements
- R1: A synchronous active-high `rst` returns the block to idle at the next edge. After reset `ads_n`, `blast_n` and `cache_n` are high, `pcd` is low, `req_ready` is high and `rsp_valid` is low. This holds even when reset arrives in the middle of a cycle.
- R2: `req_ready` is high only in idle. After a request is accepted, `ads_n` is low for exactly the next clock, with `bus_addr` equal to {line, 2'b00}. `bus_addr` holds the word address A31..A2. During the data phase a new `req_valid` is not accepted.
- R3: From the address clock through the last ready, a cacheable request drives `cache_n` low and `pcd` high together. A non-cacheable request keeps `cache_n` high and drives `pcd` from `req_nocache_hint`. Outside a cycle `cache_n` is high and `pcd` is low.
- R4: `ken_n` is sampled on the rising edge just before the edge on which the first `brdy_n` low is seen. The read becomes a four-beat burst if and only if the cache request is driven and that sample is low. Samples taken on earlier wait-state edges have no effect.
- R5: `blast_n` is low when a ready arrives for the final transfer and high for every earlier one. It is low on the first ready of a single transfer. In a burst it is high for transfers 0 to 2 and low for transfer 3.
- R6: The low two bits of `bus_addr` (A3..A2) step 0, 1, 2, 3, advancing after each ready of a burst. The upper bits (the line) stay stable from the address clock to the last ready.
- R7: A data word is captured only on an edge with `brdy_n` low. Data present during wait states is discarded. Transfer i is placed in `rsp_data[32*i +: 32]`. After a single transfer, words 1 to 3 read zero.
- R8: `rsp_cacheable` is 1 only for a burst in which `ken_n` was low on the edge just before the edge of the last ready. A single transfer always reports 0.
- R9: A request without the cacheable hint always finishes after one transfer, with `rsp_burst`=0 and `rsp_cacheable`=0, whatever `ken_n` does.
- R10: `rsp_valid` rises in the clock after the edge of the last ready. While `rsp_ready` is low it holds, and so do `rsp_data`, `rsp_burst` and `rsp_cacheable`. The block returns to idle on the edge where `rsp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this edge when high with valid |
| req_line | input | 28 | Line address (A31..A4) |
| req_cacheable | input | 1 | Core wants the line cached |
| req_nocache_hint | input | 1 | Page caching disabled hint |
| ads_n | output | 1 | Address strobe, active low |
| bus_addr | output | 30 | Word address A31..A2 |
| cache_n | output | 1 | Cache request, active low |
| pcd | output | 1 | Page-cache-disable, active high |
| blast_n | output | 1 | Burst last, active low |
| ken_n | input | 1 | Cache enable from system, active low |
| brdy_n | input | 1 | Burst ready, active low |
| bus_data | input | 32 | Read data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_data | output | 128 | Collected words, word i at bits 32*i+31..32*i |
| rsp_burst | output | 1 | Four transfers were made |
| rsp_cacheable | output | 1 | Line may be written into the cache |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 32-bit data bus and four beats per line. These values give a 16-byte line, a two-bit A3..A2 field and a 128-bit response, so the whole 0-4-8-C stepping order and the full-width response are visible at the ports. Across zero to three wait states, the bench drives `ken_n` to the opposite level on every edge except the two that count. This shows that only the edge before the first ready and the edge before the last ready are sampled.

// File: rtl/lf_pkg.sv
package lf_pkg;
  typedef enum logic [1:0] {
    LF_IDLE = 2'd0,
    LF_ADDR = 2'd1,
    LF_DATA = 2'd2,
    LF_RESP = 2'd3
  } lf_state_e;
endpackage

// File: rtl/lf_seq.sv
module lf_seq
  import lf_pkg::*;
#(
  parameter int BEATS = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_cacheable,
  input  logic                       req_nocache_hint,
  input  logic                       ken_n,
  input  logic                       brdy_n,
  input  logic                       rsp_ready,
  output logic                       ads_n,
  output logic                       blast_n,
  output logic                       cache_n,
  output logic                       pcd,
  output logic                       accept,
  output logic                       capture,
  output logic                       advance,
  output logic                       addr_phase,
  output logic                       active,
  output logic [$clog2(BEATS)-1:0]   beat,
  output logic                       rsp_valid,
  output logic                       rsp_burst,
  output logic                       rsp_cacheable
);
  localparam int BEAT_W = $clog2(BEATS);
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

  lf_state_e st;
  logic cache_req, pcd_q, ken_q, burst_q;
  logic ken_seen, go_burst;

  assign ken_seen = !ken_q;
  assign go_burst = cache_req && ken_seen;

  assign req_ready  = (st == LF_IDLE);
  assign accept     = req_valid && req_ready;
  assign addr_phase = (st == LF_ADDR);
  assign active     = (st == LF_ADDR) || (st == LF_DATA);
  assign capture    = (st == LF_DATA) && !brdy_n;
  assign advance    = capture && (burst_q ? (beat != LAST) : go_burst);
  assign rsp_valid  = (st == LF_RESP);
  assign ads_n      = !addr_phase;
  assign cache_n    = !(active && cache_req);
  assign pcd        = active && pcd_q;

  always_comb begin
    if (st != LF_DATA)  blast_n = 1'b1;
    else if (!burst_q)  blast_n = go_burst;
    else                blast_n = (beat != LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= LF_IDLE;
      beat          <= '0;
      cache_req     <= 1'b0;
      pcd_q         <= 1'b0;
      ken_q         <= 1'b1;
      burst_q       <= 1'b0;
      rsp_burst     <= 1'b0;
      rsp_cacheable <= 1'b0;
    end else begin
      case (st)
        LF_IDLE: begin
          if (accept) begin
            cache_req <= req_cacheable;
            pcd_q     <= req_cacheable || req_nocache_hint;
            beat      <= '0;
            burst_q   <= 1'b0;
            st        <= LF_ADDR;
          end
        end
        LF_ADDR: begin
          ken_q <= ken_n;
          st    <= LF_DATA;
        end
        LF_DATA: begin
          ken_q <= ken_n;
          if (!brdy_n) begin
            if (!burst_q) begin
              if (go_burst) begin
                burst_q <= 1'b1;
                beat    <= beat + BEAT_W'(1);
              end else begin
                rsp_burst     <= 1'b0;
                rsp_cacheable <= 1'b0;
                st            <= LF_RESP;
              end
            end else if (beat == LAST) begin
              rsp_burst     <= 1'b1;
              rsp_cacheable <= ken_seen;
              st            <= LF_RESP;
            end else begin
              beat <= beat + BEAT_W'(1);
            end
          end
        end
        LF_RESP: begin
          if (rsp_ready) st <= LF_IDLE;
        end
        default: st <= LF_IDLE;
      endcase
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (ads_n && blast_n && cache_n && !pcd && req_ready && !rsp_valid));

  assert_ads_one_clock_R2: assert property (@(posedge clk) disable iff (rst)
    !ads_n |=> ads_n);

  assert_pcd_with_cache_R3: assert property (@(posedge clk) disable iff (rst)
    !cache_n |-> pcd);

  assert_ken_burst_R4: assert property (@(posedge clk) disable iff (rst)
    (st == LF_DATA && !burst_q && !brdy_n && !cache_n && !$past(ken_n)) |=> !rsp_valid);

  assert_last_then_rsp_R10: assert property (@(posedge clk) disable iff (rst)
    (!blast_n && !brdy_n) |=> rsp_valid);

  assert_cacheable_needs_burst_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_cacheable) |-> rsp_burst);

  assert_uncached_single_R9: assert property (@(posedge clk) disable iff (rst)
    (st == LF_DATA && cache_n) |-> !blast_n);

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_burst) && $stable(rsp_cacheable)));
endmodule

// File: rtl/lf_addr_drv.sv
module lf_addr_drv #(
  parameter int LINE_W = 28,
  parameter int BEAT_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [LINE_W-1:0]        req_line,
  input  logic [BEAT_W-1:0]        beat,
  input  logic                     active,
  input  logic                     addr_phase,
  input  logic                     advance,
  output logic [LINE_W+BEAT_W-1:0] bus_addr
);
  logic [LINE_W-1:0] line_q;

  always_ff @(posedge clk) begin
    if (rst)       line_q <= '0;
    else if (load) line_q <= req_line;
  end

  assign bus_addr = {line_q, beat};

  assert_first_word_zero_R6: assert property (@(posedge clk) disable iff (rst)
    addr_phase |-> (bus_addr[BEAT_W-1:0] == '0));

  assert_word_steps_R6: assert property (@(posedge clk) disable iff (rst)
    (active && advance) |=> (bus_addr[BEAT_W-1:0] == $past(bus_addr[BEAT_W-1:0]) + BEAT_W'(1)));

  assert_line_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active)) |-> $stable(bus_addr[LINE_W+BEAT_W-1:BEAT_W]));
endmodule

// File: rtl/lf_line_buf.sv
module lf_line_buf #(
  parameter int DATA_W = 32,
  parameter int BEATS  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clear,
  input  logic                       capture,
  input  logic [$clog2(BEATS)-1:0]   idx,
  input  logic [DATA_W-1:0]          bus_data,
  output logic [BEATS*DATA_W-1:0]    words
);
  logic [DATA_W-1:0] mem [BEATS];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      for (int i = 0; i < BEATS; i++) mem[i] <= '0;
    end else if (capture) begin
      mem[idx] <= bus_data;
    end
  end

  for (genvar g = 0; g < BEATS; g++) begin : g_flat
    assign words[g*DATA_W +: DATA_W] = mem[g];
  end

  assert_no_capture_no_change_R7: assert property (@(posedge clk) disable iff (rst)
    (!capture && !clear) |=> $stable(words));
endmodule

// File: rtl/linefill_rd_master.sv
module linefill_rd_master #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEATS  = 4
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   req_valid,
  output logic                                   req_ready,
  input  logic [ADDR_W-$clog2(DATA_W/8)-$clog2(BEATS)-1:0] req_line,
  input  logic                                   req_cacheable,
  input  logic                                   req_nocache_hint,
  output logic                                   ads_n,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0]     bus_addr,
  output logic                                   cache_n,
  output logic                                   pcd,
  output logic                                   blast_n,
  input  logic                                   ken_n,
  input  logic                                   brdy_n,
  input  logic [DATA_W-1:0]                      bus_data,
  output logic                                   rsp_valid,
  input  logic                                   rsp_ready,
  output logic [BEATS*DATA_W-1:0]                rsp_data,
  output logic                                   rsp_burst,
  output logic                                   rsp_cacheable
);
  localparam int BYTE_W  = $clog2(DATA_W / 8);
  localparam int BEAT_W  = $clog2(BEATS);
  localparam int WADDR_W = ADDR_W - BYTE_W;
  localparam int LINE_W  = WADDR_W - BEAT_W;

  logic              accept, capture, advance, addr_phase, active;
  logic [BEAT_W-1:0] beat;

  lf_seq #(.BEATS(BEATS)) u_seq (
    .clk              (clk),
    .rst              (rst),
    .req_valid        (req_valid),
    .req_ready        (req_ready),
    .req_cacheable    (req_cacheable),
    .req_nocache_hint (req_nocache_hint),
    .ken_n            (ken_n),
    .brdy_n           (brdy_n),
    .rsp_ready        (rsp_ready),
    .ads_n            (ads_n),
    .blast_n          (blast_n),
    .cache_n          (cache_n),
    .pcd              (pcd),
    .accept           (accept),
    .capture          (capture),
    .advance          (advance),
    .addr_phase       (addr_phase),
    .active           (active),
    .beat             (beat),
    .rsp_valid        (rsp_valid),
    .rsp_burst        (rsp_burst),
    .rsp_cacheable    (rsp_cacheable)
  );

  lf_addr_drv #(.LINE_W(LINE_W), .BEAT_W(BEAT_W)) u_addr (
    .clk        (clk),
    .rst        (rst),
    .load       (accept),
    .req_line   (req_line),
    .beat       (beat),
    .active     (active),
    .addr_phase (addr_phase),
    .advance    (advance),
    .bus_addr   (bus_addr)
  );

  lf_line_buf #(.DATA_W(DATA_W), .BEATS(BEATS)) u_buf (
    .clk      (clk),
    .rst      (rst),
    .clear    (accept),
    .capture  (capture),
    .idx      (beat),
    .bus_data (bus_data),
    .words    (rsp_data)
  );

  assert_rsp_data_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> $stable(rsp_data));

  assert_no_accept_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (!ads_n || !blast_n || rsp_valid) |-> !req_ready);
endmodule

// File: tb/linefill_rd_master_tb.sv
module linefill_rd_master_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic         req_valid = 1'b0, req_cacheable = 1'b0, req_nocache_hint = 1'b0;
  logic [27:0]  req_line = '0;
  logic         ken_n = 1'b1, brdy_n = 1'b1, rsp_ready = 1'b0;
  logic [31:0]  bus_data = '0;
  logic         req_ready, ads_n, cache_n, pcd, blast_n, rsp_valid, rsp_burst, rsp_cacheable;
  logic [29:0]  bus_addr;
  logic [127:0] rsp_data;

  linefill_rd_master u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_line(req_line), .req_cacheable(req_cacheable), .req_nocache_hint(req_nocache_hint),
    .ads_n(ads_n), .bus_addr(bus_addr), .cache_n(cache_n), .pcd(pcd), .blast_n(blast_n),
    .ken_n(ken_n), .brdy_n(brdy_n), .bus_data(bus_data), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_burst(rsp_burst),
    .rsp_cacheable(rsp_cacheable)
  );

  int total = 0, bad = 0, cyc = 0;
  bit finished = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=<50000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int idx, input int b);
    return 32'hA500_0000 ^ (32'(idx) << 12) ^ (32'(b) << 4) ^ 32'h3;
  endfunction

  // field layout: [7] cacheable [6] nocache hint [5] ken asserted before first ready
  // [4] ken asserted before last ready [3:2] wait states per word [1:0] response hold cycles
  localparam logic [7:0] VEC [8] = '{
    8'b1011_0000, 8'b1010_0100, 8'b1001_0000, 8'b0111_0001,
    8'b0000_1000, 8'b1011_1010, 8'b1110_1101, 8'b0010_0111
  };

  task automatic run_txn(input int idx, input logic [27:0] line, input bit cach, input bit hint,
                         input bit kf, input bit kl, input int waits, input int hold);
    bit exp_burst, exp_cache, a, is_rdy;
    int nb, rdy0, rdyl, b, w;
    logic [127:0] exp_data, held;
    exp_burst = cach && kf;
    exp_cache = exp_burst && kl;
    nb   = exp_burst ? 4 : 1;
    rdy0 = 1 + waits;
    rdyl = 1 + (nb - 1) * (waits + 1) + waits;
    exp_data = '0;
    for (int i = 0; i < nb; i++) exp_data[i*32 +: 32] = pat(idx, i);

    req_line = line; req_cacheable = cach; req_nocache_hint = hint; req_valid = 1'b1;
    chk(req_ready == 1'b1, "R2 req_ready idle", 128'(req_ready), 1);
    @(negedge clk);
    for (int k = 0; k <= rdyl; k++) begin
      if (k == 0) begin
        chk(ads_n == 1'b0, "R2 ads_n low at address clock", 128'(ads_n), 0);
        chk(bus_addr == {line, 2'b00}, "R2 bus_addr at address clock", 128'(bus_addr), 128'({line, 2'b00}));
        req_valid = 1'b1; req_line = ~line;
        is_rdy = 1'b0; b = 0;
      end else begin
        b = (k - 1) / (waits + 1);
        w = (k - 1) % (waits + 1);
        is_rdy = (w == waits);
        chk(ads_n == 1'b1, "R2 ads_n high in data phase", 128'(ads_n), 1);
        chk(req_ready == 1'b0, "R2 no accept while busy", 128'(req_ready), 0);
        chk(bus_addr == {line, 2'(b)}, "R6 word address", 128'(bus_addr), 128'({line, 2'(b)}));
        if (is_rdy) begin
          if (b == 0) chk(blast_n == exp_burst, "R5 blast_n first ready", 128'(blast_n), 128'(exp_burst));
          else chk(blast_n == (b != nb - 1), "R5 blast_n burst", 128'(blast_n), 128'(b != nb - 1));
        end
      end
      chk(cache_n == !cach, "R3 cache_n", 128'(cache_n), 128'(!cach));
      chk(pcd == (cach || hint), "R3 pcd", 128'(pcd), 128'(cach || hint));
      if (k + 1 == rdy0) a = kf;
      else if (k + 1 == rdyl) a = kl;
      else a = (k < rdy0) ? !kf : !kl;
      ken_n    = !a;
      brdy_n   = !is_rdy;
      bus_data = is_rdy ? pat(idx, b) : (32'hDEAD_0000 + 32'(k));
      @(negedge clk);
    end
    req_valid = 1'b0; brdy_n = 1'b1; ken_n = 1'b1;
    chk(rsp_valid == 1'b1, "R10 rsp_valid after last ready", 128'(rsp_valid), 1);
    chk(rsp_burst == exp_burst, "R4 R9 rsp_burst", 128'(rsp_burst), 128'(exp_burst));
    chk(rsp_cacheable == exp_cache, "R8 rsp_cacheable", 128'(rsp_cacheable), 128'(exp_cache));
    chk(rsp_data == exp_data, "R7 rsp_data", rsp_data, exp_data);
    chk(cache_n == 1'b1 && pcd == 1'b0, "R3 strobes idle after cycle", 128'({cache_n, pcd}), 128'(2'b10));
    held = rsp_data;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid == 1'b1 && rsp_data == held, "R10 response held", rsp_data, held);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R10 idle after consume", 128'({rsp_valid, req_ready}), 128'(2'b01));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ads_n && blast_n && cache_n && !pcd, "R1 strobes after reset", 128'({ads_n, blast_n, cache_n, pcd}), 128'(4'b1110));
    chk(req_ready && !rsp_valid, "R1 handshake after reset", 128'({req_ready, rsp_valid}), 128'(2'b10));
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      run_txn(i, 28'(28'h0ABCDE0 + i * 37), VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4],
              int'(VEC[i][3:2]), int'(VEC[i][1:0]));
    end

    // R1: reset in the middle of a burst
    req_line = 28'h5555555; req_cacheable = 1'b1; req_nocache_hint = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; ken_n = 1'b0; brdy_n = 1'b1;
    @(negedge clk);
    brdy_n = 1'b0; bus_data = 32'h1111_2222;
    @(negedge clk);
    brdy_n = 1'b1; ken_n = 1'b1;
    chk(bus_addr[1:0] == 2'd1, "R6 second word before reset", 128'(bus_addr[1:0]), 1);
    rst = 1'b1;
    @(negedge clk);
    chk(ads_n && blast_n && cache_n && !pcd && req_ready && !rsp_valid, "R1 mid-cycle reset",
        128'({ads_n, blast_n, cache_n, pcd, req_ready, rsp_valid}), 128'(6'b111010));
    rst = 1'b0;
    @(negedge clk);

    // R4: ken asserted on early wait edges but not before the first ready gives a single transfer
    run_txn(20, 28'h0F0F0F0, 1'b1, 1'b0, 1'b0, 1'b1, 3, 0);
    // R9: non-cacheable with ken asserted everywhere relevant
    run_txn(21, 28'h00000FF, 1'b0, 1'b0, 1'b1, 1'b1, 0, 0);
    // R8: full burst with ken asserted before last ready after wait states
    run_txn(22, 28'hFFFFFFF, 1'b1, 1'b1, 1'b1, 1'b1, 1, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule